// File: doc/BRIEF.md
# Single-Wire Sensor Bus Master

This block is the timing engine for a master on a one-wire sensor bus. The bus is a single line with an external pull-up, shared by the master and one or more devices. Each party can only pull the line low or let it go. The block runs three operations. The first is a bus reset with presence detection. The second sends one byte. The third receives one byte. Each operation is built from fixed-length time slots. In every slot the master pulls the line low for a set number of ticks, may sample the line at a set tick, and then waits for the slot to end.

A one-cycle `tick_us` strobe is the only time base, so the timing is independent of the system clock. A client starts an operation with `cmd_valid` and an op code. It then sees `busy` for the length of the operation and a single-cycle `done` when the operation ends. The pad is modelled as an output enable (`bus_oe` high means pull low) and a raw input. The raw input passes through a two-stage synchronizer before any sample is taken. The controller has four states. ST_IDLE goes to ST_RESET, ST_WRITE or ST_READ when a command is accepted. ST_RESET returns to ST_IDLE at the end of its single slot. ST_WRITE and ST_READ return to ST_IDLE at the end of their eighth slot, and every earlier slot end moves them to the next bit.

Top module: `owm_master`

## Requirements
- R1: After reset: `busy`=0, `done`=0, `bus_oe`=0, `rx_data`=0x00 and `presence`=0.
- R2: Op codes on `cmd_op`: 2'b01 = bus reset, 2'b10 = byte write, 2'b11 = byte read, 2'b00 = no operation. A command with a nonzero op is accepted on a clock edge where `cmd_valid`=1 and `busy`=0, and `busy` is high from the next cycle.
- R3: A bus reset pulls the line low for 480 ticks, then releases it. The operation lasts 1000 ticks in total.
- R4: During a bus reset the synchronized line is sampled at tick 560 of the slot. `presence` becomes 1 if that sample was low and 0 otherwise. `presence` changes only in the cycle where a bus reset finishes.
- R5: A byte write is 8 slots of 100 ticks each, least significant bit first. A 1 bit is a 1-tick low pulse and a 0 bit is an 89-tick low pulse. The line is released for the rest of the slot.
- R6: A byte read is 8 slots of 80 ticks each. Each slot starts with a 1-tick low pulse, and the line is sampled at tick 8 of the slot. The bits are assembled least significant bit first. `rx_data` changes only in the cycle where a read finishes.
- R7: `bus_oe` is never high while `busy` is low.
- R8: A command that arrives while busy, or with op 2'b00, is ignored. It does not change the running operation's timing or result, and it does not start anything after the running operation ends.
- R9: `done` is high for exactly one cycle per operation, in the first cycle with `busy` low. A command presented in that cycle is accepted.
- R10: The slot timing advances only on cycles with `tick_us`=1. With the tick held low, `bus_oe` and `busy` hold and no operation finishes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_us | input | 1 | One-cycle timing strobe, one per microsecond |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | Operation code (see R2) |
| cmd_data | input | 8 | Byte to send for a write |
| bus_in | input | 1 | Raw line level from the pad |
| bus_oe | output | 1 | High pulls the line low; low releases it |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse at the end of an operation |
| rx_data | output | 8 | Last byte received |
| presence | output | 1 | Result of the last bus reset |

## Verification
Two events can land in the same cycle: the end-of-operation `done` pulse and the acceptance of the next command. The bench provokes this by presenting a read command in the very cycle where it first sees `done` after a write. It then requires `busy` to be high and `done` low one cycle later, and the read to return the device's byte with correct slot timing. A second coincidence is a new command while an operation is in flight. A read is injected in the middle of a write, and the write's pulse widths, its total tick count and the idle state after it are checked against values computed from the requirements.

// File: rtl/owm_pkg.sv
package owm_pkg;

    typedef enum logic [1:0] {
        OP_NONE  = 2'b00,
        OP_RESET = 2'b01,
        OP_WRITE = 2'b10,
        OP_READ  = 2'b11
    } owm_op_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RESET,
        ST_WRITE,
        ST_READ
    } owm_state_e;

endpackage

// File: rtl/owm_sync.sv
module owm_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    // Idle bus level is high, so the chain resets to ones.
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '1;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], d};
        end
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/owm_slot_timer.sv
module owm_slot_timer #(
    parameter int CW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          tick,
    output logic [CW-1:0] count
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clear) begin
            count <= '0;
        end else if (tick) begin
            count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/owm_shifter.sv
module owm_shifter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         shift,
    input  logic         shift_in,
    output logic [W-1:0] q
);
    // Right shift: bit 0 leaves first, new bits enter at the top.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (load) begin
            q <= load_val;
        end else if (shift) begin
            q <= {shift_in, q[W-1:1]};
        end
    end
endmodule

// File: rtl/owm_master.sv
module owm_master #(
    parameter int BITS       = 8,
    parameter int RST_LOW    = 480,
    parameter int RST_SAMPLE = 560,
    parameter int RST_SLOT   = 1000,
    parameter int WR_SLOT    = 100,
    parameter int WR1_LOW    = 1,
    parameter int WR0_LOW    = 89,
    parameter int RD_SLOT    = 80,
    parameter int RD_LOW     = 1,
    parameter int RD_SAMPLE  = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick_us,
    input  logic            cmd_valid,
    input  logic [1:0]      cmd_op,
    input  logic [BITS-1:0] cmd_data,
    input  logic            bus_in,
    output logic            bus_oe,
    output logic            busy,
    output logic            done,
    output logic [BITS-1:0] rx_data,
    output logic            presence
);
    import owm_pkg::*;

    localparam int CW = $clog2(RST_SLOT + 1);
    localparam int BW = (BITS > 1) ? $clog2(BITS) : 1;

    localparam logic [CW-1:0] RST_END = CW'(RST_SLOT - 1);
    localparam logic [CW-1:0] RST_SMP = CW'(RST_SAMPLE - 1);
    localparam logic [CW-1:0] RST_LO  = CW'(RST_LOW);
    localparam logic [CW-1:0] WR_END  = CW'(WR_SLOT - 1);
    localparam logic [CW-1:0] WR1_LO  = CW'(WR1_LOW);
    localparam logic [CW-1:0] WR0_LO  = CW'(WR0_LOW);
    localparam logic [CW-1:0] RD_END  = CW'(RD_SLOT - 1);
    localparam logic [CW-1:0] RD_LO   = CW'(RD_LOW);
    localparam logic [CW-1:0] RD_SMP  = CW'(RD_SAMPLE - 1);
    localparam logic [BW-1:0] LAST_BIT = BW'(BITS - 1);

    owm_state_e      state_q, state_d;
    owm_op_e         op;
    logic [CW-1:0]   slot_cnt;
    logic [CW-1:0]   end_v, smp_v, low_len;
    logic            has_smp;
    logic            line_s;
    logic [BITS-1:0] sh_q;
    logic [BW-1:0]   bit_q;
    logic            start_ok, slot_end, smp_hit, final_slot;
    logic            tmr_clear, sh_shift, sh_in;
    logic            pres_smp_q, done_q, presence_q;
    logic [BITS-1:0] rx_q;

    assign op = owm_op_e'(cmd_op);

    owm_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (bus_in),
        .q     (line_s)
    );

    owm_slot_timer #(.CW(CW)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (tmr_clear),
        .tick  (tick_us),
        .count (slot_cnt)
    );

    owm_shifter #(.W(BITS)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (start_ok),
        .load_val (cmd_data),
        .shift    (sh_shift),
        .shift_in (sh_in),
        .q        (sh_q)
    );

    // Per-state slot shape: end tick, sample tick and low-pulse length.
    always_comb begin
        end_v   = '0;
        smp_v   = '0;
        low_len = '0;
        has_smp = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                end_v = '0;
            end
            ST_RESET: begin
                end_v   = RST_END;
                smp_v   = RST_SMP;
                low_len = RST_LO;
                has_smp = 1'b1;
            end
            ST_WRITE: begin
                end_v   = WR_END;
                low_len = sh_q[0] ? WR1_LO : WR0_LO;
            end
            ST_READ: begin
                end_v   = RD_END;
                smp_v   = RD_SMP;
                low_len = RD_LO;
                has_smp = 1'b1;
            end
            default: begin
                end_v = '0;
            end
        endcase
    end

    assign start_ok   = cmd_valid && (state_q == ST_IDLE) && (op != OP_NONE);
    assign slot_end   = tick_us && (state_q != ST_IDLE) && (slot_cnt == end_v);
    assign smp_hit    = tick_us && has_smp && (slot_cnt == smp_v);
    assign final_slot = slot_end && ((state_q == ST_RESET) || (bit_q == LAST_BIT));
    assign tmr_clear  = (state_q == ST_IDLE) || slot_end;
    assign sh_shift   = ((state_q == ST_WRITE) && slot_end) ||
                        ((state_q == ST_READ) && smp_hit);
    assign sh_in      = (state_q == ST_READ) ? line_s : 1'b0;

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_ok) begin
                    unique case (op)
                        OP_RESET: state_d = ST_RESET;
                        OP_WRITE: state_d = ST_WRITE;
                        OP_READ:  state_d = ST_READ;
                        default:  state_d = ST_IDLE;
                    endcase
                end
            end
            ST_RESET: begin
                if (final_slot) state_d = ST_IDLE;
            end
            ST_WRITE, ST_READ: begin
                if (final_slot) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register and bit index.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            bit_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE) begin
                bit_q <= '0;
            end else if (slot_end) begin
                bit_q <= bit_q + 1'b1;
            end
        end
    end

    // Registered outputs: completion strobe and latched results.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_q     <= 1'b0;
            pres_smp_q <= 1'b0;
            presence_q <= 1'b0;
            rx_q       <= '0;
        end else begin
            done_q <= final_slot;
            if (smp_hit && (state_q == ST_RESET)) begin
                pres_smp_q <= ~line_s;
            end
            if (final_slot && (state_q == ST_RESET)) begin
                presence_q <= pres_smp_q;
            end
            if (final_slot && (state_q == ST_READ)) begin
                rx_q <= sh_q;
            end
        end
    end

    assign bus_oe   = (state_q != ST_IDLE) && (slot_cnt < low_len);
    assign busy     = (state_q != ST_IDLE);
    assign done     = done_q;
    assign rx_data  = rx_q;
    assign presence = presence_q;

endmodule

// File: rtl/owm_master_chk.sv
module owm_master_chk #(
    parameter int BITS = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            tick_us,
    input logic            cmd_valid,
    input logic [1:0]      cmd_op,
    input logic            bus_oe,
    input logic            busy,
    input logic            done,
    input logic [BITS-1:0] rx_data,
    input logic            presence
);
    a_r7_no_pull_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !bus_oe);

    a_r9_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r9_done_with_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    a_r9_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(busy));

    a_r2_start_needs_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ($past(cmd_valid) && ($past(cmd_op) != 2'b00)));

    a_r6_rx_only_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rx_data) |-> done);

    a_r4_presence_only_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(presence) |-> done);

    a_r10_release_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_oe) |-> $past(tick_us));

    a_r10_finish_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(tick_us));
endmodule

bind owm_master owm_master_chk #(.BITS(BITS)) u_owm_master_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_us   (tick_us),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .bus_oe    (bus_oe),
    .busy      (busy),
    .done      (done),
    .rx_data   (rx_data),
    .presence  (presence)
);

// File: tb/owm_master_bench.sv
module owm_master_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WAIT_LIMIT = 20000;
    localparam int RUN_LIMIT  = 190000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_us = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [1:0] cmd_op = 2'b00;
    logic [7:0] cmd_data = 8'h00;
    logic       bus_in;
    logic       bus_oe, busy, done, presence;
    logic [7:0] rx_data;

    int checks = 0;
    int errors = 0;

    // Tick generator and gate.
    bit tick_en = 1'b1;
    int tick_div = 0;

    // Monitor state (driven only by the monitor process).
    int  tick_tot = 0;
    int  done_tot = 0;
    int  np = 0;
    int  plen [0:511];
    int  lo_run = 0;
    int  rise_tot = 0;
    bit  oe_idle_err = 1'b0;
    logic pbusy = 1'b0, poe = 1'b0;
    int  dev_rem = 0;
    bit  rel_on = 1'b0;
    int  rel_t = 0;
    bit  dev_pull = 1'b0;
    int  cyc = 0;

    // Device configuration (driven only by the stimulus process).
    int       dev_mode = 0;     // 0 silent, 1 presence responder, 2 read responder
    int       pres_d = 0, pres_len = 0;
    logic [7:0] rd_byte = 8'h00;
    int       rd_hold = 15;
    int       rise_base = 0;

    assign bus_in = !(bus_oe || dev_pull);

    owm_master u_owm_master (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_us   (tick_us),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .cmd_data  (cmd_data),
        .bus_in    (bus_in),
        .bus_oe    (bus_oe),
        .busy      (busy),
        .done      (done),
        .rx_data   (rx_data),
        .presence  (presence)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(negedge clk) begin
        if (tick_div == 2) begin
            tick_div = 0;
            tick_us <= tick_en;
        end else begin
            tick_div = tick_div + 1;
            tick_us <= 1'b0;
        end
    end

    // Monitor and device model; t is the tick applied at the edge just passed.
    always @(negedge clk) begin
        bit t;
        t = tick_us;
        cyc = cyc + 1;
        if (t && pbusy) tick_tot = tick_tot + 1;
        if (t && poe) lo_run = lo_run + 1;
        if (poe && !bus_oe) begin
            if (np < 512) plen[np] = lo_run;
            np = np + 1;
            lo_run = 0;
        end
        if (done) done_tot = done_tot + 1;
        if (bus_oe && !busy) oe_idle_err = 1'b1;
        if (t && dev_rem > 0) dev_rem = dev_rem - 1;
        if (!poe && bus_oe && dev_mode == 2) begin
            dev_rem = rd_byte[(rise_tot - rise_base) & 7] ? 0 : rd_hold;
        end
        if (!poe && bus_oe) rise_tot = rise_tot + 1;
        if (rel_on && t) rel_t = rel_t + 1;
        if (poe && !bus_oe && dev_mode == 1) begin
            rel_on = 1'b1;
            rel_t  = 0;
        end
        if (done) rel_on = 1'b0;
        dev_pull = (dev_rem > 0) || (rel_on && rel_t >= pres_d && rel_t < pres_d + pres_len);
        pbusy = busy;
        poe = bus_oe;
        if (cyc > RUN_LIMIT) begin
            $display("FAIL watchdog: run did not finish, actual=%0d expected<=%0d", cyc, RUN_LIMIT);
            $display("CHECKS %0d ERRORS %0d", checks, errors + 1);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic start_cmd(input logic [1:0] op, input logic [7:0] d);
        cmd_valid = 1'b1;
        cmd_op    = op;
        cmd_data  = d;
        step();
        cmd_valid = 1'b0;
        cmd_op    = 2'b00;
    endtask

    task automatic wait_done();
        for (int i = 0; i < WAIT_LIMIT; i++) begin
            if (done) return;
            step();
        end
        chk(1'b0, "R9 done timeout", 0, 1);
    endtask

    function automatic int wr_len(input logic [7:0] b, input int i);
        return b[i] ? 1 : 89;
    endfunction

    function automatic logic [7:0] rd_expect(input logic [7:0] b, input int hold);
        // A zero bit is seen only if the device still holds the line at tick 8.
        return (hold > 9) ? b : 8'hFF;
    endfunction

    task automatic run_reset(input int d, input int len, input bit exp_p);
        int tb0, nb0, db0;
        dev_mode = 1; pres_d = d; pres_len = len;
        tb0 = tick_tot; nb0 = np; db0 = done_tot;
        start_cmd(2'b01, 8'h00);
        wait_done();
        chk(tick_tot - tb0 == 1000, "R3 reset duration", tick_tot - tb0, 1000);
        chk(np - nb0 == 1, "R3 reset pulse count", np - nb0, 1);
        chk(plen[nb0 % 512] == 480, "R3 reset low time", plen[nb0 % 512], 480);
        chk(presence == exp_p, "R4 presence result", presence, exp_p);
        chk(done_tot - db0 == 1, "R9 one done per op", done_tot - db0, 1);
        dev_mode = 0;
        step();
    endtask

    task automatic run_write(input logic [7:0] b);
        int tb0, nb0, db0;
        logic [7:0] rx0;
        dev_mode = 0;
        rx0 = rx_data;
        tb0 = tick_tot; nb0 = np; db0 = done_tot;
        start_cmd(2'b10, b);
        wait_done();
        chk(tick_tot - tb0 == 800, "R5 write duration", tick_tot - tb0, 800);
        chk(np - nb0 == 8, "R5 write slot count", np - nb0, 8);
        for (int i = 0; i < 8; i++) begin
            chk(plen[(nb0 + i) % 512] == wr_len(b, i), "R5 write pulse width",
                plen[(nb0 + i) % 512], wr_len(b, i));
        end
        chk(rx_data == rx0, "R6 rx kept across write", rx_data, rx0);
        chk(done_tot - db0 == 1, "R9 one done per op", done_tot - db0, 1);
        step();
    endtask

    task automatic run_read(input logic [7:0] b, input int hold);
        int tb0, nb0;
        logic [7:0] exp_b;
        logic       p0;
        dev_mode = 2; rd_byte = b; rd_hold = hold; rise_base = rise_tot;
        exp_b = rd_expect(b, hold);
        p0 = presence;
        tb0 = tick_tot; nb0 = np;
        start_cmd(2'b11, 8'h00);
        wait_done();
        chk(tick_tot - tb0 == 640, "R6 read duration", tick_tot - tb0, 640);
        chk(np - nb0 == 8, "R6 read slot count", np - nb0, 8);
        for (int i = 0; i < 8; i++) begin
            chk(plen[(nb0 + i) % 512] == 1, "R6 read start pulse", plen[(nb0 + i) % 512], 1);
        end
        chk(rx_data == exp_b, "R6 read byte", rx_data, exp_b);
        chk(presence == p0, "R4 presence kept across read", presence, p0);
        dev_mode = 0;
        step();
    endtask

    initial begin
        void'($urandom(32'd7321));
        repeat (5) step();
        // R1: reset values, read while reset is still asserted and just after.
        chk(busy == 1'b0 && bus_oe == 1'b0, "R1 idle outputs in reset", {busy, bus_oe}, 0);
        rst_n = 1'b1;
        step();
        chk(busy == 1'b0, "R1 busy after reset", busy, 0);
        chk(done == 1'b0, "R1 done after reset", done, 0);
        chk(bus_oe == 1'b0, "R1 bus_oe after reset", bus_oe, 0);
        chk(rx_data == 8'h00, "R1 rx_data after reset", rx_data, 0);
        chk(presence == 1'b0, "R1 presence after reset", presence, 0);

        // R3/R4 directed: device answers, device answers too late, device silent.
        run_reset(30, 120, 1'b1);
        run_reset(90, 60, 1'b0);
        run_reset(0, 0, 1'b0);
        for (int k = 0; k < 3; k++) begin
            bit p;
            p = $urandom_range(0, 1);
            if (p) run_reset($urandom_range(10, 60), $urandom_range(80, 200), 1'b1);
            else   run_reset(0, 0, 1'b0);
        end

        // R5 directed and random bytes.
        run_write(8'h00);
        run_write(8'hFF);
        run_write(8'hA5);
        for (int k = 0; k < 4; k++) run_write(8'($urandom_range(0, 255)));

        // R6: sample point corners (device releases before / after tick 8).
        run_read(8'h3C, 15);
        run_read(8'h00, 6);
        run_read(8'h81, 10);
        for (int k = 0; k < 4; k++) run_read(8'($urandom_range(0, 255)), $urandom_range(11, 30));

        // R8: no-op code while idle.
        cmd_valid = 1'b1; cmd_op = 2'b00; cmd_data = 8'h55;
        step();
        cmd_valid = 1'b0;
        step();
        chk(busy == 1'b0 && bus_oe == 1'b0, "R8 op 00 ignored", busy, 0);

        // R8: read injected in the middle of a write.
        begin
            int tb0, nb0;
            logic [7:0] rx0;
            rx0 = rx_data;
            tb0 = tick_tot; nb0 = np;
            start_cmd(2'b10, 8'h6B);
            repeat (400) step();
            start_cmd(2'b11, 8'h00);
            wait_done();
            chk(tick_tot - tb0 == 800, "R8 write timing kept", tick_tot - tb0, 800);
            for (int i = 0; i < 8; i++) begin
                chk(plen[(nb0 + i) % 512] == wr_len(8'h6B, i), "R8 write pulses kept",
                    plen[(nb0 + i) % 512], wr_len(8'h6B, i));
            end
            repeat (10) step();
            chk(busy == 1'b0, "R8 no late start", busy, 0);
            chk(rx_data == rx0, "R8 rx untouched", rx_data, rx0);
        end

        // R9: new command presented in the done cycle.
        begin
            int tb1;
            start_cmd(2'b10, 8'h0F);
            wait_done();
            chk(busy == 1'b0, "R9 idle in done cycle", busy, 0);
            dev_mode = 2; rd_byte = 8'hC6; rd_hold = 15; rise_base = rise_tot;
            tb1 = tick_tot;
            start_cmd(2'b11, 8'h00);
            chk(busy == 1'b1 && done == 1'b0, "R9 accepted in done cycle", {busy, done}, 2);
            wait_done();
            chk(tick_tot - tb1 == 640, "R9 chained read duration", tick_tot - tb1, 640);
            chk(rx_data == 8'hC6, "R9 chained read byte", rx_data, 8'hC6);
            dev_mode = 0;
            step();
        end

        // R10: tick held low mid-operation freezes the slot.
        begin
            int tb0, db0;
            logic oe0;
            tb0 = tick_tot; db0 = done_tot;
            start_cmd(2'b10, 8'hE2);
            repeat (150) step();
            tick_en = 1'b0;
            repeat (4) step();
            oe0 = bus_oe;
            repeat (60) step();
            chk(bus_oe == oe0, "R10 bus_oe frozen", bus_oe, oe0);
            chk(busy == 1'b1, "R10 busy held", busy, 1);
            chk(done_tot == db0, "R10 no finish while paused", done_tot, db0);
            tick_en = 1'b1;
            wait_done();
            chk(tick_tot - tb0 == 800, "R10 duration counts ticks only", tick_tot - tb0, 800);
            step();
        end

        chk(oe_idle_err == 1'b0, "R7 no pull while idle", oe_idle_err, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule